// File: doc/BRIEF.md
# Modem Line Status Register

This block is the read-only modem status register of a serial port. It watches four active-low modem handshake pins: clear-to-send, data-set-ready, ring indicator and carrier detect. Each pin passes through a synchroniser. The register shows the present level of each line as an active-high bit in its upper nibble. Its lower nibble holds sticky change flags. A read of the register clears the flags. Any set flag can raise a level interrupt, gated by an enable bit.

In loopback mode the pins are ignored. The four upper bits then take their values from the modem-control outputs of the port (request-to-send, terminal-ready and the two general-purpose outputs). Change detection works on whichever source is selected. Bus address decoding and the other registers of the port sit outside this block.

Top module: `modem_status_reg`

## Requirements
- R1: While rst_ni is low, rdata_o reads 8'h00 and irq_o is 0. The synchronisers reset to the inactive (high) pin level.
- R2: Outside loopback, rdata_o[4], [5], [6] and [7] are the inverse of cts_n_i, dsr_n_i, ri_n_i and cd_n_i. A pin change shows on the third rising clock edge after it is applied: two synchroniser flops, then the status register.
- R3: rdata_o[0], [1] and [3] set when status bits 4, 5 and 7 change in either direction, on the same edge that the status bit updates.
- R4: rdata_o[2] sets only when status bit 6 goes from 1 to 0, which is the end of ringing (ri_n_i rising). A 0-to-1 change of bit 6 sets no flag.
- R5: A set change flag holds until a clock edge on which rd_i is high. That edge clears all four flags.
- R6: A change detected on the same edge as a read leaves its flag set. Other flags still clear on that edge.
- R7: When loop_en_i is high, rdata_o[7:4] equals {out2_i, out1_i, dtr_i, rts_i} one clock edge after they are applied. The four pins have no effect on rdata_o.
- R8: In loopback, the change flags follow the substituted levels. out1_i falling sets rdata_o[2]. Switching loop_en_i sets the flag of every status bit whose value changes.
- R9: irq_o is high exactly while irq_en_i is high and at least one of rdata_o[3:0] is set. It is a level, not a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| cd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| loop_en_i | input | 1 | Loopback mode select |
| rts_i | input | 1 | Request-to-send control bit, status source in loopback |
| dtr_i | input | 1 | Terminal-ready control bit, status source in loopback |
| out1_i | input | 1 | General output 1, stands in for ring indicator in loopback |
| out2_i | input | 1 | General output 2, stands in for carrier detect in loopback |
| irq_en_i | input | 1 | Modem status interrupt enable |
| rd_i | input | 1 | Register read strobe, clears the change flags |
| rdata_o | output | 8 | {cd, ri, dsr, cts status, cd, ri, dsr, cts change flags} |
| irq_o | output | 1 | Modem status interrupt, level |

## Verification
The bench drives ring indicator edges in both directions. A design that flags both edges, or only the leading one, shows a wrong bit 2. A read strobe is timed onto the exact edge where a new change lands. A design that lets the clear win loses the new flag, and one that skips the clear keeps stale flags. The bench drives the pins low during loopback and then leaves loopback. This exposes pin leakage into the status bits and a missing delta when the source switches. Turning off the interrupt enable while flags are set catches an interrupt that is not gated or not held as a level.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned LINES = 4;
  typedef logic [LINES-1:0] line_t;
  // line order: 0 cts, 1 dsr, 2 ri, 3 cd
  localparam line_t TRAIL_MASK = 4'b0100;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
  parameter int unsigned N = 4,
  parameter logic [N-1:0] TRAIL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic         clr_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] stat_q, flag_q, chg;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (TRAIL[i]) begin : g_trail
      assign chg[i] = stat_q[i] & ~lvl_i[i];
      AST_TRAIL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_q[i]) |-> $fell(stat_q[i])); // R4
    end else begin : g_any
      assign chg[i] = stat_q[i] ^ lvl_i[i];
      AST_ANY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(stat_q[i]) |-> flag_q[i]); // R3
    end
    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i && flag_q[i] |=> flag_q[i]); // R5
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      flag_q <= '0;
    end else begin
      stat_q <= lvl_i;
      flag_q <= (clr_i ? '0 : flag_q) | chg;
    end
  end

  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && (lvl_i == stat_q) |=> flag_q == '0); // R5

  assign stat_o = stat_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       cd_n_i,
  input  logic       loop_en_i,
  input  logic       rts_i,
  input  logic       dtr_i,
  input  logic       out1_i,
  input  logic       out2_i,
  input  logic       irq_en_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  line_t pin_n, pin_s_n, mcr, lvl, stat, flag;

  assign pin_n = {cd_n_i, ri_n_i, dsr_n_i, cts_n_i};
  assign mcr   = {out2_i, out1_i, dtr_i, rts_i};

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_n),
    .q_o   (pin_s_n)
  );

  // pins are active low; loopback substitutes the control bits
  assign lvl = loop_en_i ? mcr : ~pin_s_n;

  msr_delta #(.N(LINES), .TRAIL(TRAIL_MASK)) u_delta (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .clr_i (rd_i),
    .stat_o(stat),
    .flag_o(flag)
  );

  assign rdata_o = {stat, flag};
  assign irq_o   = irq_en_i & (|flag);

  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else live_q <= 1'b1;
  end

  AST_RST_CLEAN: assert property (@(posedge clk_i)
    !rst_ni |-> (rdata_o == 8'h00) && !irq_o); // R1
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_i && (rdata_o[3:0] != 4'h0) |-> irq_o); // R9
  AST_LOOP_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(loop_en_i) |-> rdata_o[7:4] == $past(mcr)); // R7
endmodule

// File: tb/sim_modem_status_reg.sv
module sim_modem_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic loop_en = 1'b0, rts = 1'b0, dtr = 1'b0, out1 = 1'b0, out2 = 1'b0;
  logic irq_en = 1'b1, rd = 1'b0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modem_status_reg u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .cd_n_i(cd_n),
    .loop_en_i(loop_en), .rts_i(rts), .dtr_i(dtr), .out1_i(out1), .out2_i(out2),
    .irq_en_i(irq_en), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  // {loop, mcr{out2,out1,dtr,rts}, pins_n{cd,ri,dsr,cts}, expected rdata}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'h0, 4'hE, 8'h11},  // R2 R3 cts low
    {1'b0, 4'h0, 4'hF, 8'h01},  // R3 cts back
    {1'b0, 4'h0, 4'hD, 8'h22},  // R3 dsr low
    {1'b0, 4'h0, 4'hB, 8'h42},  // R4 ri leading: no flag
    {1'b0, 4'h0, 4'hF, 8'h04},  // R4 ri trailing
    {1'b0, 4'h0, 4'h7, 8'h88},  // R3 cd low
    {1'b0, 4'h0, 4'h0, 8'hF3},  // R2 all low
    {1'b0, 4'h0, 4'hF, 8'h0F},  // R3 R4 all release
    {1'b1, 4'h5, 4'hF, 8'h51},  // R7 R8 rts out1
    {1'b1, 4'hA, 4'hF, 8'hAF},  // R8 out1 falls
    {1'b1, 4'hA, 4'h0, 8'hA0},  // R7 pins ignored
    {1'b0, 4'hA, 4'h0, 8'hF1},  // R8 leave loopback
    {1'b0, 4'h0, 4'hF, 8'h0F}   // R2 R4 release
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {irq, rdata}, 9'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {irq, rdata}, 9'h000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      loop_en = VEC[i][16];
      {out2, out1, dtr, rts} = VEC[i][15:12];
      {cd_n, ri_n, dsr_n, cts_n} = VEC[i][11:8];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check($sformatf("R2/R3/R4/R7/R8/R9 vec %0d", i), {irq, rdata},
            {|VEC[i][3:0], VEC[i][7:0]});
      do_read();
      check($sformatf("R5 clear vec %0d", i), {irq, rdata}, {1'b0, VEC[i][7:4], 4'h0});
    end

    // R5: flags hold without read
    @(negedge clk) cts_n = 1'b0;
    repeat (13) @(negedge clk);
    check("R5 sticky", {irq, rdata}, 9'h111);

    // R9: enable gates a held level
    irq_en = 1'b0;
    @(negedge clk);
    check("R9 masked", {irq, rdata}, 9'h011);
    irq_en = 1'b1;
    @(negedge clk);
    check("R9 level", {irq, rdata}, 9'h111);
    do_read();

    // R6: change lands on the read edge; older flag clears
    @(negedge clk) dsr_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 setup", {irq, rdata}, 9'h132);
    cts_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    check("R6 same-edge change", {irq, rdata}, 9'h121);
    do_read();
    check("R6 then clear", {irq, rdata}, 9'h020);

    // R4: ring start alone sets no flag
    @(negedge clk) ri_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 ring start", {irq, rdata}, 9'h060);
    ri_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 ring end", {irq, rdata}, 9'h124);

    // R1: reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 async reset", {irq, rdata}, 9'h000);

    done = 1'b1;
    finish_run();
  end
endmodule